// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block gathers up to 32 maskable peripheral request lines and one non-maskable request. It turns them into a single decision for an exception sequencer: which source should be serviced next, and whether that source may interrupt the handler that is running now. Each request is caught in a sticky pending bit. Each maskable source carries an enable bit and a programmable urgency level. All of these are held in a small word-addressed register file that software reads and writes.

The arbiter keeps a stack of the urgency ranks of the handlers that are in progress. The top of this stack is the current execution rank. A pending, enabled source is offered to the sequencer only when it is strictly more urgent than that rank. The sequencer answers with an acknowledge, which pushes the winner's rank and clears its pending bit. When the handler finishes, the sequencer gives a return, which pops the stack. Nesting therefore needs no software help. Register stacking, vector fetch and power control belong to the sequencer and core, outside this block.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset, `take_o` is 0 and `active_rank_o` is 5 (idle). The enable, pending and level registers all read 0.
- R2: Each source has an 8-bit level field that keeps only its upper 2 bits. A read returns those 2 bits with the low 6 bits zero. Sources 4k..4k+3 share the word at address 32+k, and source 4k+j sits in bits [8j+7:8j].
- R3: Address 0 holds the enable mask (read and write). A write to address 1 sets every pending bit whose data bit is 1. A write to address 2 clears every pending bit whose data bit is 1. Both addresses read back the pending mask.
- R4: A request line that is high in a cycle makes its pending bit 1 from the next cycle on, and the bit stays set after the line drops. If a set and a clear reach the same bit in the same cycle, the set wins.
- R5: Among the pending, enabled sources, the winner is the one with the lowest level value. On equal levels, the lowest source number wins. The winner's number appears on `take_id_o`.
- R6: A disabled source keeps its pending bit but never wins. Once it is enabled, it competes again.
- R7: The non-maskable request cannot be disabled, appears as number 32 and rank 0, and is more urgent than every programmable level.
- R8: Ranks are encoded as 0 for the non-maskable source, level+1 for a programmable level, and 5 for idle. `take_o` is 1 only when the winner's rank is strictly lower than `active_rank_o`, so a source with an equal rank never preempts.
- R9: An acknowledge while `take_o` is 1 pushes the winner's rank onto the active stack and clears that source's pending bit. An acknowledge while `take_o` is 0 has no effect.
- R10: A return pops the active stack. A return while the stack is empty is ignored. When an acknowledge and a return arrive in the same cycle, only the acknowledge acts.
- R11: The active stack nests five deep: one handler per programmable level plus the non-maskable one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 32 | Maskable request lines |
| nmi_i | input | 1 | Non-maskable request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ack_i | input | 1 | Sequencer accepts the offered source |
| ret_i | input | 1 | Sequencer finished the innermost handler |
| take_o | output | 1 | A source may preempt now |
| take_id_o | output | 6 | Winning source number (32 = non-maskable) |
| active_rank_o | output | 3 | Current execution rank |

## Verification
A sweep enables exactly one source at a time, over every source and every level. This separates the source-number path from the level path and confirms that each acknowledge pushes the rank that matches the level. A second sweep raises two sources over all 16 level pairs, chosen so that the pairs include neighbours and both ends of the index range; it exposes errors in level comparison and in tie-breaking. A staged chain builds a nest five deep through every level and the non-maskable request, interleaving same-rank requests, disabled sources, coincident set and clear, and stray acknowledges and returns, to tell strict preemption apart from less-or-equal preemption.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // rank 0 is reserved for the non-maskable source
  localparam int NMI_RANK = 0;

  function automatic int lvl_rank(input int lvl);
    return lvl + 1;
  endfunction

  function automatic int idle_rank(input int prio_bits);
    return (1 << prio_bits) + 1;
  endfunction

  // stored level bits placed in the top of an 8-bit field
  function automatic logic [7:0] field_view(input logic [7:0] lvl, input int prio_bits);
    return lvl << (8 - prio_bits);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic            nmi_i,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] ack_clr,
  input  logic            ack_nmi,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en,
  output logic            nmi_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      en       <= '0;
      nmi_pend <= 1'b0;
    end else begin
      // a set beats a clear that lands in the same cycle
      pend     <= (pend & ~(sw_clr | ack_clr)) | irq_i | sw_set;
      nmi_pend <= (nmi_pend & ~ack_nmi) | nmi_i;
      if (en_we) en <= en_wdata;
    end
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NSRC      = 32,
  parameter int PRIO_BITS = 2,
  parameter int WIW       = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [WIW-1:0]            widx,
  input  logic [31:0]               wdata,
  output logic [NSRC*PRIO_BITS-1:0] prio_flat
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam int WORD = s / 4;
    localparam int FLD  = s % 4;
    logic [PRIO_BITS-1:0] lvl_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else if (we && widx == WIW'(WORD)) lvl_q <= wdata[8*FLD+7 -: PRIO_BITS];
    end
    assign prio_flat[s*PRIO_BITS +: PRIO_BITS] = lvl_q;
  end
endmodule

// File: rtl/irq_winner_pick.sv
module irq_winner_pick
  import irq_arb_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int PRIO_BITS = 2,
  parameter int RW        = 3,
  parameter int IDW       = 6
) (
  input  logic [NSRC-1:0]           cand,
  input  logic [NSRC*PRIO_BITS-1:0] prio_flat,
  input  logic                      nmi_pend,
  output logic                      win_valid,
  output logic [IDW-1:0]            win_id,
  output logic [RW-1:0]             win_rank
);
  localparam logic [RW-1:0] IDLE_R = RW'(idle_rank(PRIO_BITS));

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_rank  = IDLE_R;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int s = 0; s < NSRC; s++) begin
      if (cand[s] && RW'(lvl_rank(int'(prio_flat[s*PRIO_BITS +: PRIO_BITS]))) < win_rank) begin
        win_valid = 1'b1;
        win_id    = IDW'(s);
        win_rank  = RW'(lvl_rank(int'(prio_flat[s*PRIO_BITS +: PRIO_BITS])));
      end
    end
    if (nmi_pend) begin
      win_valid = 1'b1;
      win_id    = IDW'(NSRC);
      win_rank  = RW'(NMI_RANK);
    end
  end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
  parameter int DEPTH  = 5,
  parameter int RW     = 3,
  parameter int DW     = 3,
  parameter int IDLE_R = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [RW-1:0] push_rank,
  input  logic          pop,
  output logic [RW-1:0] top_rank,
  output logic [DW-1:0] depth
);
  logic [RW-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (push && depth < DW'(DEPTH)) begin
      slot[depth] <= push_rank;
      depth       <= depth + 1'b1;
    end else if (pop && depth != '0) begin
      depth <= depth - 1'b1;
    end
  end

  assign top_rank = (depth == '0) ? RW'(IDLE_R) : slot[depth - 1'b1];
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              nmi_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              take_o,
  output logic [$clog2(NSRC+1)-1:0] take_id_o,
  output logic [$clog2((1<<PRIO_BITS)+2)-1:0] active_rank_o
);
  localparam int IDW       = $clog2(NSRC + 1);
  localparam int IDLE_R    = idle_rank(PRIO_BITS);
  localparam int RW        = $clog2(IDLE_R + 1);
  localparam int DEPTH     = (1 << PRIO_BITS) + 1;
  localparam int DW        = $clog2(DEPTH + 1);
  localparam int NWORD     = (NSRC + 3) / 4;
  localparam int WIW       = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int A_EN      = 0;
  localparam int A_PSET    = 1;
  localparam int A_PCLR    = 2;
  localparam int PRIO_BASE = 32;

  // named internal events, observed by the bound checker
  logic [NSRC-1:0]           pend_q, en_q, ack_clr;
  logic                      nmi_pend_q, ack_nmi;
  logic [NSRC*PRIO_BITS-1:0] prio_flat;
  logic                      win_valid, push_evt, pop_evt, prio_sel;
  logic [IDW-1:0]            win_id;
  logic [RW-1:0]             win_rank, top_rank;
  logic [DW-1:0]             stk_depth;
  logic [ADDR_W-1:0]         prio_off;
  logic [WIW-1:0]            widx;

  assign prio_off = reg_addr - ADDR_W'(PRIO_BASE);
  assign prio_sel = (int'(reg_addr) >= PRIO_BASE) && (int'(prio_off) < NWORD);
  assign widx     = prio_off[WIW-1:0];

  assign take_o        = win_valid && (win_rank < top_rank);
  assign take_id_o     = win_id;
  assign active_rank_o = top_rank;
  assign push_evt      = ack_i && take_o;
  assign pop_evt       = ret_i && !push_evt && (stk_depth != '0);
  assign ack_nmi       = push_evt && (int'(win_id) == NSRC);

  always_comb begin
    ack_clr = '0;
    for (int s = 0; s < NSRC; s++)
      if (push_evt && int'(win_id) == s) ack_clr[s] = 1'b1;
  end

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
    .sw_set((reg_we && int'(reg_addr) == A_PSET) ? reg_wdata[NSRC-1:0] : '0),
    .sw_clr((reg_we && int'(reg_addr) == A_PCLR) ? reg_wdata[NSRC-1:0] : '0),
    .ack_clr(ack_clr), .ack_nmi(ack_nmi),
    .en_we(reg_we && int'(reg_addr) == A_EN), .en_wdata(reg_wdata[NSRC-1:0]),
    .pend(pend_q), .en(en_q), .nmi_pend(nmi_pend_q)
  );

  irq_prio_regs #(.NSRC(NSRC), .PRIO_BITS(PRIO_BITS), .WIW(WIW)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(reg_we && prio_sel), .widx(widx),
    .wdata(reg_wdata), .prio_flat(prio_flat)
  );

  irq_winner_pick #(.NSRC(NSRC), .PRIO_BITS(PRIO_BITS), .RW(RW), .IDW(IDW)) u_pick (
    .cand(pend_q & en_q), .prio_flat(prio_flat), .nmi_pend(nmi_pend_q),
    .win_valid(win_valid), .win_id(win_id), .win_rank(win_rank)
  );

  irq_active_stack #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .IDLE_R(IDLE_R)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_rank(win_rank),
    .pop(pop_evt), .top_rank(top_rank), .depth(stk_depth)
  );

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_addr) == A_EN) begin
      reg_rdata[NSRC-1:0] = en_q;
    end else if (int'(reg_addr) == A_PSET || int'(reg_addr) == A_PCLR) begin
      reg_rdata[NSRC-1:0] = pend_q;
    end else if (prio_sel) begin
      for (int f = 0; f < 4; f++) begin
        if (int'(widx) * 4 + f < NSRC)
          reg_rdata[8*f +: 8] = field_view(8'(prio_flat[(int'(widx)*4+f)*PRIO_BITS +: PRIO_BITS]), PRIO_BITS);
      end
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NSRC  = 32,
  parameter int IDW   = 6,
  parameter int RW    = 3,
  parameter int DW    = 3,
  parameter int DEPTH = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_i,
  input logic            take_o,
  input logic [IDW-1:0]  take_id_o,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] en_q,
  input logic            nmi_pend_q,
  input logic            push_evt,
  input logic            pop_evt,
  input logic [RW-1:0]   win_rank,
  input logic [RW-1:0]   top_rank,
  input logic [DW-1:0]   stk_depth
);
  logic id_live;
  always_comb begin
    id_live = (int'(take_id_o) == NSRC) && nmi_pend_q;
    for (int s = 0; s < NSRC; s++)
      if (int'(take_id_o) == s) id_live = pend_q[s] && en_q[s];
  end

  // R6
  offered_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> id_live);

  // R9
  push_lands_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> top_rank == $past(win_rank));

  // R10
  pop_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> stk_depth == DW'($past(stk_depth) - 1'b1));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stk_depth) <= DEPTH);

  // R7
  nmi_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_i |=> nmi_pend_q);

  // R8
  nothing_beats_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_rank == '0) |-> !take_o);
endmodule

bind irq_nest_arbiter irq_arb_chk #(
  .NSRC(NSRC), .IDW(IDW), .RW(RW), .DW(DW), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_o(take_o), .take_id_o(take_id_o),
  .pend_q(pend_q), .en_q(en_q), .nmi_pend_q(nmi_pend_q), .push_evt(push_evt),
  .pop_evt(pop_evt), .win_rank(win_rank), .top_rank(top_rank), .stk_depth(stk_depth)
);

// File: tb/test_irq_nest_arbiter.sv
module test_irq_nest_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic        nmi_i = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ack_i = 1'b0, ret_i = 1'b0;
  logic        take_o;
  logic [5:0]  take_id_o;
  logic [2:0]  active_rank_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int lvl_m [32];

  always #10 clk = ~clk;

  irq_nest_arbiter i_irq_nest_arbiter (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_i(ack_i), .ret_i(ret_i), .take_o(take_o), .take_id_o(take_id_o),
    .active_rank_o(active_rank_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    tick;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 6'(a); #1; d = reg_rdata;
  endtask

  task automatic put_word(input int k);
    logic [31:0] d = '0;
    for (int j = 0; j < 4; j++) d[8*j +: 8] = 8'(lvl_m[4*k+j] * 64 + 17 * j);
    wr(32 + k, d);
  endtask

  task automatic set_lvl(input int s, input int p);
    lvl_m[s] = p; put_word(s / 4);
  endtask

  task automatic do_ack; ack_i = 1'b1; tick; ack_i = 1'b0; endtask
  task automatic do_ret; ret_i = 1'b1; tick; ret_i = 1'b0; endtask
  task automatic pulse(input logic [31:0] m); irq_i = m; tick; irq_i = '0; endtask
  task automatic expect_take(input string tag, input int id);
    chk({tag, " take"}, take_o, 1); chk({tag, " id"}, take_id_o, id);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int s = 0; s < 32; s++) lvl_m[s] = 0;
    tick; tick; rst_n = 1'b1; tick;

    // R1 reset state
    chk("R1 take", take_o, 0);
    chk("R1 rank", active_rank_o, 5);
    rd(0, d); chk("R1 enable", d, 0);
    rd(1, d); chk("R1 pending", d, 0);
    for (int k = 0; k < 8; k++) begin rd(32 + k, d); chk("R1 level", d, 0); end

    // R2 level field storage: only the top two bits survive
    for (int k = 0; k < 8; k++) begin
      logic [31:0] pat = 32'h9E3779B9 * 32'(k + 1);
      wr(32 + k, pat);
      rd(32 + k, d); chk("R2 readback", d, pat & 32'hC0C0C0C0);
    end
    for (int k = 0; k < 8; k++) wr(32 + k, 32'h0);

    // R3/R5/R9/R10 single-source sweep over every source and level
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        set_lvl(s, p);
        wr(0, 32'h1 << s);
        rd(0, d); chk("R3 enable rw", d, 32'h1 << s);
        wr(1, 32'h1 << s);
        rd(1, d); chk("R3 set pend", d, 32'h1 << s);
        expect_take("R5 single", s);
        do_ack;
        chk("R9 pushed rank", active_rank_o, p + 1);
        rd(2, d); chk("R9 pend cleared", d, 0);
        chk("R9 no take after", take_o, 0);
        do_ret;
        chk("R10 pop idle", active_rank_o, 5);
      end
      set_lvl(s, 0);
    end

    // R5 pair sweep: level order, then lowest index on ties
    begin
      int pick [6] = '{0, 1, 6, 13, 30, 31};
      wr(0, 32'hFFFFFFFF);
      for (int i = 0; i < 6; i++)
        for (int j = i + 1; j < 6; j++)
          for (int pa = 0; pa < 4; pa++)
            for (int pb = 0; pb < 4; pb++) begin
              int a = pick[i], b = pick[j];
              int w = (pb < pa) ? b : a;
              set_lvl(a, pa); set_lvl(b, pb);
              pulse((32'h1 << a) | (32'h1 << b));
              expect_take("R5 pair", w);
              wr(2, 32'hFFFFFFFF);
              chk("R3 clear all", take_o, 0);
            end
      for (int s = 0; s < 32; s++) lvl_m[s] = 0;
      for (int k = 0; k < 8; k++) put_word(k);
    end

    // R4 sticky pending, and set winning over clear
    wr(0, 32'h0);
    pulse(32'h0000_0100);
    tick; tick;
    rd(1, d); chk("R4 sticky", d, 32'h0000_0100);
    irq_i = 32'h0000_0100; reg_we = 1'b1; reg_addr = 6'd2; reg_wdata = 32'h0000_0100;
    tick; irq_i = '0; reg_we = 1'b0;
    rd(1, d); chk("R4 set beats clear", d, 32'h0000_0100);
    wr(2, 32'h0000_0100);
    rd(1, d); chk("R3 clear", d, 0);

    // R6 disabled source waits pending
    set_lvl(5, 1);
    pulse(32'h20);
    chk("R6 disabled no take", take_o, 0);
    rd(1, d); chk("R6 still pending", d, 32'h20);
    wr(0, 32'h20);
    expect_take("R6 enabled", 5);
    wr(2, 32'h20);

    // R9/R10 stray handshakes
    do_ack; chk("R9 stray ack", active_rank_o, 5);
    do_ret; chk("R10 empty ret", active_rank_o, 5);

    // R8/R11/R7 five-deep nest
    set_lvl(3, 3); set_lvl(9, 3); set_lvl(12, 2); set_lvl(15, 1); set_lvl(20, 0);
    wr(0, 32'h0010_9208);
    pulse(32'h8); expect_take("R8 first", 3); do_ack;
    chk("R8 rank lvl3", active_rank_o, 4);
    pulse(32'h200); chk("R8 equal no preempt", take_o, 0);
    pulse(32'h1000); expect_take("R8 more urgent", 12); do_ack;
    pulse(32'h8000); expect_take("R8 lvl1", 15); do_ack;
    pulse(32'h0010_0000); expect_take("R8 lvl0", 20); do_ack;
    chk("R8 rank lvl0", active_rank_o, 1);
    nmi_i = 1'b1; tick; nmi_i = 1'b0;
    expect_take("R7 nmi over lvl0", 32); do_ack;
    chk("R11 depth five rank", active_rank_o, 0);
    nmi_i = 1'b1; tick; nmi_i = 1'b0;
    chk("R7 nmi under nmi", take_o, 0);
    wr(0, 32'h0);
    do_ret; chk("R10 pop to lvl0", active_rank_o, 1);
    expect_take("R7 nmi unmaskable", 32); do_ack;
    chk("R11 five again", active_rank_o, 0);
    do_ret; chk("R10 back lvl0", active_rank_o, 1);
    do_ret; chk("R10 back lvl1", active_rank_o, 2);
    do_ret; chk("R10 back lvl2", active_rank_o, 3);
    wr(0, 32'h0010_9208);
    do_ret; chk("R10 back lvl3", active_rank_o, 4);
    chk("R8 still equal", take_o, 0);
    do_ret; chk("R10 idle", active_rank_o, 5);
    expect_take("R8 waiting source", 9); do_ack;
    do_ret;

    // R10 ack wins over ret in the same cycle
    wr(0, 32'h80); set_lvl(7, 0);
    pulse(32'h80);
    ack_i = 1'b1; ret_i = 1'b1; tick; ack_i = 1'b0; ret_i = 1'b0;
    chk("R10 ack precedence", active_rank_o, 1);
    do_ret; chk("R10 final pop", active_rank_o, 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule